// File: doc/BRIEF.md
# Quad multiply with paired add/subtract and final sum

This arithmetic slice multiplies four operand pairs, combines the first two products and the last two products each with a selectable add or subtract, and adds the two partial results into one wide output. Signedness is chosen separately for the A operand group and the B operand group. Nothing is lost to overflow, because each intermediate value is one bit wider than its inputs.

Three register stages sit on the data path: the operand input stage, the stage after the multipliers, and the output stage. Each stage can be built in or bypassed by parameter, and each picks one of four clocks, one of four clock enables and one of four synchronous resets. The sign and operation controls travel through the same stages as the data they govern.

The A and B operand input registers can also be turned into shift lines. In that mode operands enter through a chain input and leave through a chain output, so neighbouring slices can be connected in series.

Top module: `quad_mul_addsub_sum`

## Requirements
- R1: With `sub0` = 1 the first pair result is A0·B0 − A1·B1, and with `sub0` = 0 it is A0·B0 + A1·B1. `sub1` selects the same way for A2·B2 and A3·B3. `sum_out` is the first pair result plus the second, taken modulo 2^(AW+BW+2).
- R2: With `sgn_a` = 1 all four A operands are two's complement values, and with `sgn_a` = 0 they are unsigned. `sgn_b` sets the B operands the same way. The two controls are independent of each other.
- R3: Each product is AW+BW bits wide, each pair result is AW+BW+1 bits, and `sum_out` is AW+BW+2 bits. For every operand value, including the extremes, `sum_out` equals the exact mathematical result with no wrap.
- R4: A new set of operands and controls shows up on `sum_out` after IN_EN+PL_EN+OUT_EN rising edges. The sign and add/subtract controls are delayed by the same amount as the operands they were applied with.
- R5: An enabled stage whose selected clock enable is low keeps its contents. The other stages keep working.
- R6: An enabled stage whose selected reset is high at its clock edge clears to zero, whatever its enable is. Enables and resets that a stage did not select have no effect on it.
- R7: With A_CHAIN = 1 the A input registers form a shift line. Lane 0 loads `a_chain_in`, lane k loads lane k−1, and `a_in` is ignored. `a_chain_out` always carries the A operand held for lane 3, which is the registered `a_in[3]` when chaining is off. B_CHAIN, `b_chain_in` and `b_chain_out` work the same way for B.
- R8: A stage built with its EN parameter at 0 passes its value through without a register. For example, a slice with only the input stage enabled has a latency of one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 4 | Four clock sources; each stage selects one |
| ce | input | 4 | Four clock enables, active high |
| rst | input | 4 | Four synchronous resets, active high |
| a_in | input | 4×AW | Parallel A operands, lane k in element k |
| b_in | input | 4×BW | Parallel B operands, lane k in element k |
| sgn_a | input | 1 | 1: A operands are two's complement |
| sgn_b | input | 1 | 1: B operands are two's complement |
| sub0 | input | 1 | 1: first pair subtracts lane 1 product |
| sub1 | input | 1 | 1: second pair subtracts lane 3 product |
| a_chain_in | input | AW | A shift line input (lane 0) |
| b_chain_in | input | BW | B shift line input (lane 0) |
| sum_out | output | AW+BW+2 | Final sum |
| a_chain_out | output | AW | A operand held for lane 3 |
| b_chain_out | output | BW | B operand held for lane 3 |

## Verification
With all three stages enabled, a change applied between edges reaches `sum_out` after the third following rising edge. The bench holds that value through the second edge, then reads it right after the third edge at the falling edge, so an early control or a short pipeline shows up as a mismatch. A stage-reset or enable event acts on the very next edge of its own stage. The effect then moves through the remaining stages one edge apiece, and the expected value at each falling edge is worked out in that order. The chained variant has only its input stage, so its sum is due one edge after each shift, and its chain output is due four shifts after a value enters.

// File: rtl/qmas_pkg.sv
package qmas_pkg;
  localparam int NLANE = 4;
  localparam int NSRC  = 4;

  typedef struct packed {
    logic sa;
    logic sb;
    logic sub0;
    logic sub1;
  } qmas_ctl_t;
endpackage

// File: rtl/qmas_stage.sv
module qmas_stage #(
  parameter int W  = 8,
  parameter bit EN = 1'b1,
  parameter int CK = 0,
  parameter int CE = 0,
  parameter int RS = 0
) (
  input  logic [qmas_pkg::NSRC-1:0] clks,
  input  logic [qmas_pkg::NSRC-1:0] ces,
  input  logic [qmas_pkg::NSRC-1:0] rsts,
  input  logic [W-1:0]              d,
  output logic [W-1:0]              q
);
  logic unused_sel;
  assign unused_sel = ^{clks, ces, rsts};

  generate
    if (EN) begin : g_reg
      logic [W-1:0] r;
      always_ff @(posedge clks[CK]) begin
        if (rsts[RS])     r <= '0;
        else if (ces[CE]) r <= d;
      end
      assign q = r;
    end else begin : g_thru
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/qmas_mult.sv
module qmas_mult #(
  parameter int AW = 9,
  parameter int BW = 9
) (
  input  logic [AW-1:0]    a,
  input  logic [BW-1:0]    b,
  input  logic             sa,
  input  logic             sb,
  output logic [AW+BW-1:0] p
);
  localparam int PW = AW + BW;

  logic [PW-1:0] aw, bw;
  assign aw = {{(PW-AW){sa & a[AW-1]}}, a};
  assign bw = {{(PW-BW){sb & b[BW-1]}}, b};
  assign p  = aw * bw;
endmodule

// File: rtl/qmas_addsub.sv
module qmas_addsub #(
  parameter int IW = 18
) (
  input  logic [IW-1:0] x,
  input  logic [IW-1:0] y,
  input  logic          xs,
  input  logic          ys,
  input  logic          sub,
  output logic [IW:0]   r
);
  logic [IW:0] xe, ye;
  assign xe = {xs & x[IW-1], x};
  assign ye = {ys & y[IW-1], y};
  assign r  = sub ? (xe - ye) : (xe + ye);
endmodule

// File: rtl/quad_mul_addsub_sum.sv
module quad_mul_addsub_sum
  import qmas_pkg::*;
#(
  parameter int AW      = 9,
  parameter int BW      = 9,
  parameter bit IN_EN   = 1'b1,
  parameter int IN_CLK  = 0,
  parameter int IN_CE   = 0,
  parameter int IN_RST  = 0,
  parameter bit PL_EN   = 1'b1,
  parameter int PL_CLK  = 1,
  parameter int PL_CE   = 1,
  parameter int PL_RST  = 1,
  parameter bit OUT_EN  = 1'b1,
  parameter int OUT_CLK = 2,
  parameter int OUT_CE  = 2,
  parameter int OUT_RST = 2,
  parameter bit A_CHAIN = 1'b0,
  parameter bit B_CHAIN = 1'b0
) (
  input  logic [3:0]             clk,
  input  logic [3:0]             ce,
  input  logic [3:0]             rst,
  input  logic [3:0][AW-1:0]     a_in,
  input  logic [3:0][BW-1:0]     b_in,
  input  logic                   sgn_a,
  input  logic                   sgn_b,
  input  logic                   sub0,
  input  logic                   sub1,
  input  logic [AW-1:0]          a_chain_in,
  input  logic [BW-1:0]          b_chain_in,
  output logic [AW+BW+1:0]       sum_out,
  output logic [AW-1:0]          a_chain_out,
  output logic [BW-1:0]          b_chain_out
);
  localparam int PW = AW + BW;
  localparam int SW = PW + 1;
  localparam int OW = PW + 2;
  localparam int CW = $bits(qmas_ctl_t);

  logic unused_ok;
  assign unused_ok = ^{a_in, b_in, a_chain_in, b_chain_in};

  logic [AW-1:0] a_q    [NLANE];
  logic [BW-1:0] b_q    [NLANE];
  logic [PW-1:0] prod   [NLANE];
  logic [PW-1:0] prod_q [NLANE];

  qmas_ctl_t ctl_d, ctl_q1, ctl_q2;
  assign ctl_d = '{sa: sgn_a, sb: sgn_b, sub0: sub0, sub1: sub1};

  // control path: same stages as the operands so they stay aligned
  qmas_stage #(.W(CW), .EN(IN_EN), .CK(IN_CLK), .CE(IN_CE), .RS(IN_RST)) u_ctl_in (
    .clks(clk), .ces(ce), .rsts(rst), .d(ctl_d), .q(ctl_q1)
  );
  qmas_stage #(.W(CW), .EN(PL_EN), .CK(PL_CLK), .CE(PL_CE), .RS(PL_RST)) u_ctl_pl (
    .clks(clk), .ces(ce), .rsts(rst), .d(ctl_q1), .q(ctl_q2)
  );

  generate
    for (genvar k = 0; k < NLANE; k++) begin : g_lane
      logic [AW-1:0] a_d;
      logic [BW-1:0] b_d;

      if (A_CHAIN && k > 0) begin : g_a_shift
        assign a_d = a_q[k-1];
      end else if (A_CHAIN) begin : g_a_head
        assign a_d = a_chain_in;
      end else begin : g_a_par
        assign a_d = a_in[k];
      end

      if (B_CHAIN && k > 0) begin : g_b_shift
        assign b_d = b_q[k-1];
      end else if (B_CHAIN) begin : g_b_head
        assign b_d = b_chain_in;
      end else begin : g_b_par
        assign b_d = b_in[k];
      end

      qmas_stage #(.W(AW), .EN(IN_EN), .CK(IN_CLK), .CE(IN_CE), .RS(IN_RST)) u_a_reg (
        .clks(clk), .ces(ce), .rsts(rst), .d(a_d), .q(a_q[k])
      );
      qmas_stage #(.W(BW), .EN(IN_EN), .CK(IN_CLK), .CE(IN_CE), .RS(IN_RST)) u_b_reg (
        .clks(clk), .ces(ce), .rsts(rst), .d(b_d), .q(b_q[k])
      );

      qmas_mult #(.AW(AW), .BW(BW)) u_mult (
        .a(a_q[k]), .b(b_q[k]), .sa(ctl_q1.sa), .sb(ctl_q1.sb), .p(prod[k])
      );

      qmas_stage #(.W(PW), .EN(PL_EN), .CK(PL_CLK), .CE(PL_CE), .RS(PL_RST)) u_p_reg (
        .clks(clk), .ces(ce), .rsts(rst), .d(prod[k]), .q(prod_q[k])
      );
    end
  endgenerate

  // products are signed whenever either operand group is signed
  logic          prod_sgn;
  logic [SW-1:0] pair0, pair1;
  logic [OW-1:0] sum_d;
  assign prod_sgn = ctl_q2.sa | ctl_q2.sb;

  qmas_addsub #(.IW(PW)) u_pair0 (
    .x(prod_q[0]), .y(prod_q[1]), .xs(prod_sgn), .ys(prod_sgn),
    .sub(ctl_q2.sub0), .r(pair0)
  );
  qmas_addsub #(.IW(PW)) u_pair1 (
    .x(prod_q[2]), .y(prod_q[3]), .xs(prod_sgn), .ys(prod_sgn),
    .sub(ctl_q2.sub1), .r(pair1)
  );

  // a difference can be negative even for unsigned operands
  qmas_addsub #(.IW(SW)) u_total (
    .x(pair0), .y(pair1),
    .xs(prod_sgn | ctl_q2.sub0), .ys(prod_sgn | ctl_q2.sub1),
    .sub(1'b0), .r(sum_d)
  );

  qmas_stage #(.W(OW), .EN(OUT_EN), .CK(OUT_CLK), .CE(OUT_CE), .RS(OUT_RST)) u_out_reg (
    .clks(clk), .ces(ce), .rsts(rst), .d(sum_d), .q(sum_out)
  );

  assign a_chain_out = a_q[NLANE-1];
  assign b_chain_out = b_q[NLANE-1];
endmodule

// File: rtl/qmas_chk.sv
module qmas_chk #(
  parameter int AW      = 9,
  parameter int BW      = 9,
  parameter bit IN_EN   = 1'b1,
  parameter int IN_CLK  = 0,
  parameter int IN_CE   = 0,
  parameter int IN_RST  = 0,
  parameter bit OUT_EN  = 1'b1,
  parameter int OUT_CLK = 2,
  parameter int OUT_CE  = 2,
  parameter int OUT_RST = 2,
  parameter bit A_CHAIN = 1'b0,
  parameter bit B_CHAIN = 1'b0
) (
  input logic [3:0]       clk,
  input logic [3:0]       ce,
  input logic [3:0]       rst,
  input logic [AW-1:0]    a_chain_in,
  input logic [BW-1:0]    b_chain_in,
  input logic [AW+BW+1:0] sum_out,
  input logic [AW-1:0]    a_chain_out,
  input logic [BW-1:0]    b_chain_out
);
  logic unused_chk;
  assign unused_chk = ^{clk, ce, rst, a_chain_in, b_chain_in, sum_out, a_chain_out, b_chain_out};

  generate
    if (OUT_EN) begin : g_out
      p_out_hold_r5: assert property (@(posedge clk[OUT_CLK]) disable iff (rst[OUT_RST])
        !ce[OUT_CE] |=> $stable(sum_out));
      p_out_clear_r6: assert property (@(posedge clk[OUT_CLK])
        rst[OUT_RST] |=> (sum_out == '0));
    end

    if (IN_EN) begin : g_in
      p_in_clear_r6: assert property (@(posedge clk[IN_CLK])
        rst[IN_RST] |=> (a_chain_out == '0 && b_chain_out == '0));
    end

    if (IN_EN && (A_CHAIN || B_CHAIN)) begin : g_chain
      // consecutive enabled input edges, saturating at 3
      logic [1:0] run;
      always_ff @(posedge clk[IN_CLK]) begin
        if (rst[IN_RST] || !ce[IN_CE]) run <= 2'd0;
        else if (run != 2'd3)          run <= run + 2'd1;
      end
      if (A_CHAIN) begin : g_a
        p_chain_a_r7: assert property (@(posedge clk[IN_CLK]) disable iff (rst[IN_RST])
          (run == 2'd3 && ce[IN_CE]) |=> (a_chain_out == $past(a_chain_in, 4)));
      end
      if (B_CHAIN) begin : g_b
        p_chain_b_r7: assert property (@(posedge clk[IN_CLK]) disable iff (rst[IN_RST])
          (run == 2'd3 && ce[IN_CE]) |=> (b_chain_out == $past(b_chain_in, 4)));
      end
    end
  endgenerate
endmodule

bind quad_mul_addsub_sum qmas_chk #(
  .AW(AW), .BW(BW),
  .IN_EN(IN_EN), .IN_CLK(IN_CLK), .IN_CE(IN_CE), .IN_RST(IN_RST),
  .OUT_EN(OUT_EN), .OUT_CLK(OUT_CLK), .OUT_CE(OUT_CE), .OUT_RST(OUT_RST),
  .A_CHAIN(A_CHAIN), .B_CHAIN(B_CHAIN)
) u_chk (
  .clk(clk), .ce(ce), .rst(rst),
  .a_chain_in(a_chain_in), .b_chain_in(b_chain_in),
  .sum_out(sum_out), .a_chain_out(a_chain_out), .b_chain_out(b_chain_out)
);

// File: tb/tb_quad_mul_addsub_sum.sv
`timescale 1ns/1ps
module tb_quad_mul_addsub_sum;
  logic       clk = 1'b0;
  logic [3:0] clks, ce, rst;
  logic [3:0][8:0] a_in, b_in;
  logic       sgn_a, sgn_b, sub0, sub1;
  logic [8:0] a_ci, b_ci;
  logic [19:0] sum, sum_sh;
  logic [8:0] a_co, b_co, a_co_sh, b_co_sh;
  int total = 0, bad = 0;
  bit done = 1'b0;

  assign clks = {4{clk}};
  always #2 clk = ~clk;

  quad_mul_addsub_sum dut (
    .clk(clks), .ce(ce), .rst(rst), .a_in(a_in), .b_in(b_in),
    .sgn_a(sgn_a), .sgn_b(sgn_b), .sub0(sub0), .sub1(sub1),
    .a_chain_in(a_ci), .b_chain_in(b_ci),
    .sum_out(sum), .a_chain_out(a_co), .b_chain_out(b_co)
  );

  quad_mul_addsub_sum #(
    .IN_EN(1'b1), .IN_CLK(3), .IN_CE(3), .IN_RST(3),
    .PL_EN(1'b0), .OUT_EN(1'b0), .A_CHAIN(1'b1), .B_CHAIN(1'b1)
  ) dut_sh (
    .clk(clks), .ce(ce), .rst(rst), .a_in(a_in), .b_in(b_in),
    .sgn_a(sgn_a), .sgn_b(sgn_b), .sub0(sub0), .sub1(sub1),
    .a_chain_in(a_ci), .b_chain_in(b_ci),
    .sum_out(sum_sh), .a_chain_out(a_co_sh), .b_chain_out(b_co_sh)
  );

  function automatic longint opv(input logic [8:0] x, input logic s);
    return (s && x[8]) ? longint'(x) - 512 : longint'(x);
  endfunction

  function automatic logic [19:0] model(input logic [8:0] a0, a1, a2, a3,
                                        input logic [8:0] b0, b1, b2, b3,
                                        input logic sa, sb, s0, s1);
    longint p0 = opv(a0, sa) * opv(b0, sb);
    longint p1 = opv(a1, sa) * opv(b1, sb);
    longint p2 = opv(a2, sa) * opv(b2, sb);
    longint p3 = opv(a3, sa) * opv(b3, sb);
    longint f  = (s0 ? p0 - p1 : p0 + p1) + (s1 ? p2 - p3 : p2 + p3);
    return f[19:0];
  endfunction

  function automatic logic [19:0] model_now();
    return model(a_in[0], a_in[1], a_in[2], a_in[3], b_in[0], b_in[1], b_in[2], b_in[3],
                 sgn_a, sgn_b, sub0, sub1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ops(input logic [8:0] a0, a1, a2, a3, b0, b1, b2, b3,
                         input logic sa, sb, s0, s1);
    a_in[0] = a0; a_in[1] = a1; a_in[2] = a2; a_in[3] = a3;
    b_in[0] = b0; b_in[1] = b1; b_in[2] = b2; b_in[3] = b3;
    sgn_a = sa; sgn_b = sb; sub0 = s0; sub1 = s1;
  endtask

  task automatic t_reset();
    ce = 4'hF; rst = 4'hF;
    set_ops(9'd3, 9'd5, 9'd7, 9'd11, 9'd13, 9'd2, 9'd4, 9'd6, 1'b0, 1'b0, 1'b0, 1'b0);
    a_ci = 9'h0AA; b_ci = 9'h055;
    cyc(4);
    chk("R6 reset sum", sum, 0);
    chk("R6 reset chain out A", a_co, 0);
    chk("R6 reset chain out B", b_co, 0);
    chk("R6 reset chained sum", sum_sh, 0);
    chk("R6 reset chained out A", a_co_sh, 0);
    rst = 4'h0;
  endtask

  task automatic t_pattern(input string tag, input logic [8:0] a0, a1, a2, a3,
                           input logic [8:0] b0, b1, b2, b3, input logic sa, sb, s0, s1);
    set_ops(a0, a1, a2, a3, b0, b1, b2, b3, sa, sb, s0, s1);
    cyc(3);
    chk(tag, sum, model_now());
    chk("R7 chain out is registered lane 3 A", a_co, a_in[3]);
  endtask

  task automatic t_values();
    t_pattern("R1 unsigned add/add", 9'd3, 9'd5, 9'd7, 9'd11, 9'd13, 9'd2, 9'd4, 9'd6,
              1'b0, 1'b0, 1'b0, 1'b0);
    chk("R1 known value 143", sum, 20'd143);
    t_pattern("R1 unsigned sub/sub", 9'd100, 9'd20, 9'd3, 9'd50, 9'd7, 9'd9, 9'd4, 9'd30,
              1'b0, 1'b0, 1'b1, 1'b1);
    t_pattern("R2 both signed", 9'h1F0, 9'h005, 9'h1FF, 9'h080, 9'h003, 9'h1FE, 9'h100, 9'h1FF,
              1'b1, 1'b1, 1'b0, 1'b1);
    t_pattern("R2 A signed B unsigned", 9'h1F0, 9'h005, 9'h1FF, 9'h080, 9'h003, 9'h1FE, 9'h100, 9'h1FF,
              1'b1, 1'b0, 1'b0, 1'b1);
    t_pattern("R2 A unsigned B signed", 9'h1F0, 9'h005, 9'h1FF, 9'h080, 9'h003, 9'h1FE, 9'h100, 9'h1FF,
              1'b0, 1'b1, 1'b1, 1'b0);
    t_pattern("R3 unsigned maxima", 9'h1FF, 9'h1FF, 9'h1FF, 9'h1FF, 9'h1FF, 9'h1FF, 9'h1FF, 9'h1FF,
              1'b0, 1'b0, 1'b0, 1'b0);
    chk("R3 no wrap at 1044484", sum, 20'd1044484);
    t_pattern("R3 signed minima add", 9'h100, 9'h100, 9'h100, 9'h100, 9'h100, 9'h100, 9'h100, 9'h100,
              1'b1, 1'b1, 1'b0, 1'b0);
    chk("R3 no wrap at 262144", sum, 20'd262144);
    t_pattern("R3 unsigned deep negative", 9'd0, 9'h1FF, 9'd0, 9'h1FF, 9'd0, 9'h1FF, 9'd0, 9'h1FF,
              1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_latency();
    logic [19:0] e1, e2;
    set_ops(9'd3, 9'd5, 9'd7, 9'd11, 9'd13, 9'd2, 9'd4, 9'd6, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(3);
    e1 = model_now();
    set_ops(9'h1F0, 9'd5, 9'd7, 9'd11, 9'd13, 9'd2, 9'd4, 9'd6, 1'b1, 1'b0, 1'b1, 1'b0);
    e2 = model_now();
    cyc(2);
    chk("R4 old value before third edge", sum, e1);
    cyc(1);
    chk("R4 new value with aligned controls", sum, e2);
  endtask

  task automatic t_enable();
    logic [19:0] e_old, e3, e4;
    e_old = model_now();
    ce[2] = 1'b0;
    set_ops(9'd21, 9'd4, 9'd9, 9'd1, 9'd8, 9'd8, 9'd2, 9'd200, 1'b0, 1'b0, 1'b0, 1'b1);
    e3 = model_now();
    cyc(5);
    chk("R5 output stage held", sum, e_old);
    ce[2] = 1'b1;
    cyc(1);
    chk("R5 output resumes one edge later", sum, e3);
    ce[0] = 1'b0;
    set_ops(9'd40, 9'd41, 9'd42, 9'd43, 9'd1, 9'd2, 9'd3, 9'd4, 1'b0, 1'b0, 1'b1, 1'b0);
    e4 = model_now();
    cyc(4);
    chk("R5 input stage held", sum, e3);
    ce[0] = 1'b1;
    cyc(3);
    chk("R5 input stage resumes", sum, e4);
  endtask

  task automatic t_reset_sel();
    logic [19:0] e4;
    e4 = model_now();
    rst[2] = 1'b1;
    cyc(1);
    chk("R6 output stage reset", sum, 0);
    rst[2] = 1'b0;
    cyc(1);
    chk("R6 output reload after reset", sum, e4);
    rst[1] = 1'b1;
    cyc(1);
    chk("R6 pipeline reset leaves output", sum, e4);
    rst[1] = 1'b0;
    cyc(1);
    chk("R6 cleared pipeline reaches output", sum, 0);
    cyc(1);
    chk("R6 pipeline refilled", sum, e4);
    rst[3] = 1'b1; ce[3] = 1'b0;
    cyc(2);
    chk("R6 unselected reset and enable ignored", sum, e4);
    rst[3] = 1'b0; ce[3] = 1'b1;
  endtask

  task automatic t_chain();
    logic [8:0] av [4];
    logic [8:0] bv [4];
    logic [19:0] e;
    av[0] = 9'h1FD; av[1] = 9'h00C; av[2] = 9'h100; av[3] = 9'h07F;
    bv[0] = 9'h00A; bv[1] = 9'h1FF; bv[2] = 9'h003; bv[3] = 9'h0C8;
    set_ops(9'd77, 9'd77, 9'd77, 9'd77, 9'd99, 9'd99, 9'd99, 9'd99, 1'b1, 1'b0, 1'b0, 1'b1);
    rst[3] = 1'b1;
    cyc(1);
    rst[3] = 1'b0;
    chk("R6 chained input stage cleared", a_co_sh, 0);
    for (int i = 0; i < 4; i++) begin
      a_ci = av[i]; b_ci = bv[i];
      cyc(1);
      if (i == 0) chk("R7 first shift not yet at chain end", a_co_sh, 0);
      if (i == 2) begin
        e = model(av[2], av[1], av[0], 9'd0, bv[2], bv[1], bv[0], 9'd0, 1'b1, 1'b0, 1'b0, 1'b1);
        chk("R8 one-edge latency, partial chain", sum_sh, e);
      end
    end
    chk("R7 A chain out after four shifts", a_co_sh, av[0]);
    chk("R7 B chain out after four shifts", b_co_sh, bv[0]);
    e = model(av[3], av[2], av[1], av[0], bv[3], bv[2], bv[1], bv[0], 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R7 chained operands, parallel ignored", sum_sh, e);
    ce[3] = 1'b0;
    a_ci = 9'h055; b_ci = 9'h0AA;
    cyc(2);
    chk("R5 chain held when enable low", a_co_sh, av[0]);
    chk("R5 chained sum held", sum_sh, e);
    ce[3] = 1'b1;
  endtask

  initial begin
    t_reset();
    t_values();
    t_latency();
    t_enable();
    t_reset_sel();
    t_chain();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule